// File: doc/BRIEF.md
# Multiprocessor Interrupt Level Controller

This block resolves interrupt priority for a small cluster of up to four processors. System interrupt lines feed one shared 32-bit pending register. A disable mask filters that register. Each pending bit maps through a parameter table to a priority level from 1 to 15, and the highest unmasked level goes to the one processor named in the routing register. Each processor also owns a private pending register. Software raises and lowers interrupts in it through set and clear writes on bits 31..17, and bit n of that range stands for level n-16.

Each processor receives a combined 4-bit level, which is the larger of its software level and, when it is the routing target, the shared level. When the processor has nothing outstanding, the block latches an interrupt index built from the external-interrupt trap code and the level, and it raises a one-cycle request strobe. The index stays held until the processor acknowledges it. A wake output tells a halted processor that a nonzero level is waiting, even while its request is held back. Interrupt line changes arrive as events that carry a line number, a level and a selector: an all-ones selector addresses the shared register and any other value addresses one processor's private register.

Top module: `mp_irq_level_ctl`

## Requirements
- R1: A write to per-processor address {1, cpu[1:0], 0} ORs only bits 31..17 of the write data into that processor's private pending register. Bits 16..0 of that register always read as zero. A read at the same address returns the register.
- R2: A write to per-processor address {1, cpu[1:0], 1} clears those private pending bits among 31..17 that are set in the write data, and leaves the other bits unchanged.
- R3: A processor's software level is the index of its highest set private bit among 17..31, minus 16. The level is 0 when none of those bits is set.
- R4: The shared level is the largest LEVEL_MAP entry over the bits set in the shared pending register (read at address 0x0) and clear in the disable mask (read and written at address 0x1). It is 0 when no such bit exists.
- R5: The shared level reaches only the processor held in the routing register (address 0x2, reset value 0). The level output of that processor is the larger of its shared level and its software level.
- R6: When a processor's latched index is 0, its acknowledge is low and its level is nonzero, the next clock edge latches index EXT_TT | level (default 0x10 | level) and pulses the request for exactly one cycle. While the index is nonzero, it holds and no request is issued.
- R7: An acknowledge clears the latched index at the next edge. A level that is still pending is latched again, with a new request, one edge later.
- R8: The wake output is high while a processor's halted input is high and its level output is nonzero, whether or not a request is being held back.
- R9: A line event with the all-ones selector sets or clears shared pending bit ev_num to follow ev_level. With any other selector it sets or clears private bit 16+LEVEL_MAP[ev_num] of that processor. Events whose line maps to level 0 change nothing.
- R10: Processor indices at or above NCPU are inert. Writes and events addressed to them change nothing, and reads of them return 0. A routing write of such an index leaves the routing register unchanged.
- R11: After reset, all pending registers, the mask, the routing register, the indices, the requests and the levels are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset 0x0..0xF |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| ev_valid | input | 1 | Interrupt line event valid |
| ev_num | input | 5 | Line number 0..31 |
| ev_level | input | 1 | New line level |
| ev_sel | input | CPU_W+1 | Target processor; all-ones selects the shared register |
| cpu_halted | input | NCPU | Per-processor halted status |
| cpu_ack | input | NCPU | Per-processor acknowledge |
| cpu_level | output | 4*NCPU | Presented level per processor |
| cpu_req | output | NCPU | One-cycle request strobe per processor |
| cpu_wake | output | NCPU | Wake indication per processor |
| cpu_index | output | 8*NCPU | Latched interrupt index per processor |

## Verification
The bench builds the block with NCPU=3. The two-bit processor field in the address and the selector then has one code, index 3, that names no processor, so writes, reads, events and routing writes that land on an absent processor can all be driven. The default LEVEL_MAP gives lines 0 and 16 a level of 0, which brings the ignored-event case of R9 within reach. It also gives several lines the same priority, so shared-level maxima can be checked when masked and unmasked lines compete.

// File: rtl/mp_irq_level_ctl.sv
module mp_irq_level_ctl #(
  parameter int NCPU = 4,
  parameter logic [127:0] LEVEL_MAP = 128'hFEDCBA9876543210_FEDCBA9876543210,
  parameter logic [7:0] EXT_TT = 8'h10,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int SEL_W = CPU_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_valid,
  input  logic                  bus_write,
  input  logic [3:0]            bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic                  ev_valid,
  input  logic [4:0]            ev_num,
  input  logic                  ev_level,
  input  logic [SEL_W-1:0]      ev_sel,
  input  logic [NCPU-1:0]       cpu_halted,
  input  logic [NCPU-1:0]       cpu_ack,
  output logic [4*NCPU-1:0]     cpu_level,
  output logic [NCPU-1:0]       cpu_req,
  output logic [NCPU-1:0]       cpu_wake,
  output logic [8*NCPU-1:0]     cpu_index
);
  localparam logic [31:0] SOFT_MASK = 32'hFFFE_0000;

  logic [31:0]            gpend, gmask;
  logic [CPU_W-1:0]       target;
  logic [NCPU-1:0][31:0]  spend, spend_nxt;
  logic [NCPU-1:0][7:0]   idx;
  logic [NCPU-1:0][3:0]   slvl, lvl;
  logic [NCPU-1:0]        req_q;
  logic [3:0]             glvl;

  wire       wr       = bus_valid & bus_write;
  wire [3:0] ev_map   = LEVEL_MAP[{ev_num, 2'b00} +: 4];
  wire       ev_glob  = &ev_sel;
  wire       ev_act   = ev_valid & (ev_map != 4'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpend  <= '0;
      gmask  <= '0;
      target <= '0;
    end else begin
      if (ev_act && ev_glob)
        gpend[ev_num] <= ev_level;
      if (wr && bus_addr == 4'h1)
        gmask <= bus_wdata;
      if (wr && bus_addr == 4'h2 && bus_wdata < 32'(NCPU))
        target <= bus_wdata[CPU_W-1:0];
    end
  end

  always_comb begin
    glvl = '0;
    for (int i = 0; i < 32; i++)
      if (gpend[i] && !gmask[i] && LEVEL_MAP[i*4 +: 4] > glvl)
        glvl = LEVEL_MAP[i*4 +: 4];
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    wire bus_hit = wr && bus_addr[3] && (int'(bus_addr[2:1]) == c);
    wire ev_hit  = ev_act && !ev_glob && (int'(ev_sel) == c);

    always_comb begin
      spend_nxt[c] = spend[c];
      if (bus_hit) begin
        if (bus_addr[0])
          spend_nxt[c] = spend_nxt[c] & ~(bus_wdata & SOFT_MASK);
        else
          spend_nxt[c] = spend_nxt[c] | (bus_wdata & SOFT_MASK);
      end
      if (ev_hit)
        spend_nxt[c][{1'b1, ev_map}] = ev_level;
    end

    always_comb begin
      slvl[c] = '0;
      for (int j = 17; j < 32; j++)
        if (spend[c][j])
          slvl[c] = 4'(j - 16);
    end

    assign lvl[c] = ((int'(target) == c) && glvl > slvl[c]) ? glvl : slvl[c];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        spend[c] <= '0;
        idx[c]   <= '0;
        req_q[c] <= 1'b0;
      end else begin
        spend[c] <= spend_nxt[c];
        req_q[c] <= !cpu_ack[c] && idx[c] == 8'd0 && lvl[c] != 4'd0;
        if (cpu_ack[c])
          idx[c] <= '0;
        else if (idx[c] == 8'd0 && lvl[c] != 4'd0)
          idx[c] <= EXT_TT | {4'd0, lvl[c]};
      end
    end

    assign cpu_level[c*4 +: 4] = lvl[c];
    assign cpu_index[c*8 +: 8] = idx[c];
    assign cpu_req[c]          = req_q[c];
    assign cpu_wake[c]         = cpu_halted[c] && lvl[c] != 4'd0;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[3]) begin
      for (int c = 0; c < NCPU; c++)
        if (int'(bus_addr[2:1]) == c)
          bus_rdata = spend[c];
    end else begin
      case (bus_addr)
        4'h0:    bus_rdata = gpend;
        4'h1:    bus_rdata = gmask;
        4'h2:    bus_rdata = 32'(target);
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mp_irq_level_ctl_chk.sv
module mp_irq_level_ctl_chk #(
  parameter int NCPU = 4,
  parameter logic [7:0] EXT_TT = 8'h10,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NCPU-1:0]       cpu_req,
  input logic [NCPU-1:0]       cpu_ack,
  input logic [4*NCPU-1:0]     cpu_level,
  input logic [8*NCPU-1:0]     cpu_index,
  input logic [CPU_W-1:0]      target,
  input logic [NCPU-1:0][31:0] spend
);
  AST_TARGET_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(target) < NCPU); // R10

  for (genvar c = 0; c < NCPU; c++) begin : g_chk
    AST_SOFT_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      spend[c][16:0] == 17'd0); // R1

    AST_REQ_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req[c] |-> $past(cpu_index[c*8 +: 8]) == 8'd0 && cpu_index[c*8 +: 8] != 8'd0); // R6

    AST_INDEX_CARRIES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req[c] |-> cpu_index[c*8 +: 8] == (EXT_TT | {4'd0, $past(cpu_level[c*4 +: 4])})); // R6

    AST_INDEX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_index[c*8 +: 8] != 8'd0 && !cpu_ack[c]) |=> $stable(cpu_index[c*8 +: 8]) && !cpu_req[c]); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack[c] |=> cpu_index[c*8 +: 8] == 8'd0 && !cpu_req[c]); // R7
  end
endmodule

bind mp_irq_level_ctl mp_irq_level_ctl_chk #(.NCPU(NCPU), .EXT_TT(EXT_TT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ack(cpu_ack),
  .cpu_level(cpu_level), .cpu_index(cpu_index), .target(target), .spend(spend)
);

// File: tb/mp_irq_level_ctl_tb.sv
module mp_irq_level_ctl_tb;
  localparam int NCPU = 3;
  localparam int SEL_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic ev_valid = 1'b0, ev_level = 1'b0;
  logic [4:0] ev_num = '0;
  logic [SEL_W-1:0] ev_sel = '0;
  logic [NCPU-1:0] cpu_halted = '0, cpu_ack = '1;
  logic [4*NCPU-1:0] cpu_level;
  logic [NCPU-1:0] cpu_req, cpu_wake;
  logic [8*NCPU-1:0] cpu_index;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  mp_irq_level_ctl #(.NCPU(NCPU)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_valid(ev_valid), .ev_num(ev_num), .ev_level(ev_level), .ev_sel(ev_sel),
    .cpu_halted(cpu_halted), .cpu_ack(cpu_ack), .cpu_level(cpu_level),
    .cpu_req(cpu_req), .cpu_wake(cpu_wake), .cpu_index(cpu_index)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic ev(input logic [SEL_W-1:0] s, input logic [4:0] n, input logic l);
    ev_valid = 1'b1; ev_sel = s; ev_num = n; ev_level = l;
    @(posedge clk); @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // {set data, expected software level}
  localparam logic [35:0] VEC [6] = '{
    {32'h0002_0000, 4'd1},
    {32'h8000_0000, 4'd15},
    {32'h0001_FFFF, 4'd0},
    {32'hA002_0000, 4'd15},
    {32'h0104_0000, 4'd8},
    {32'h0F00_0000, 4'd11}
  };

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 levels", 32'(cpu_level), 32'd0);
    chk("R11 index", 32'(cpu_index[23:0]), 32'd0);
    chk("R11 req", 32'(cpu_req), 32'd0);
    rd(4'h0, d); chk("R11 gpend", d, 32'd0);
    rd(4'h2, d); chk("R11 target", d, 32'd0);

    // R1 R3 table on cpu1, ack held high
    foreach (VEC[k]) begin
      wr(4'hA, VEC[k][35:4]);
      chk("R3 soft level", 32'(cpu_level[7:4]), 32'(VEC[k][3:0]));
      rd(4'hA, d); chk("R1 set readback", d, VEC[k][35:4] & 32'hFFFE_0000);
      wr(4'hB, 32'hFFFF_FFFF);
      chk("R2 clear all", 32'(cpu_level[7:4]), 32'd0);
    end

    // R4 R5 R9 shared path
    ev(3'b111, 5'd5, 1'b1);
    chk("R4 level5 cpu0", 32'(cpu_level[3:0]), 32'd5);
    chk("R5 not cpu1", 32'(cpu_level[7:4]), 32'd0);
    ev(3'b111, 5'd20, 1'b1);
    chk("R4 max keeps 5", 32'(cpu_level[3:0]), 32'd5);
    ev(3'b111, 5'd13, 1'b1);
    chk("R4 level13", 32'(cpu_level[3:0]), 32'd13);
    wr(4'h1, 32'h0000_2000);
    chk("R4 masked 13", 32'(cpu_level[3:0]), 32'd5);
    ev(3'b111, 5'd16, 1'b1);
    rd(4'h0, d); chk("R9 gpend map0 ignored", d, 32'h0010_2020);
    ev(3'b111, 5'd5, 1'b0);
    chk("R9 clear line5", 32'(cpu_level[3:0]), 32'd4);

    // R6 R7 R8 request path cpu0
    cpu_ack[0] = 1'b0;
    tick();
    chk("R6 req", 32'(cpu_req[0]), 32'd1);
    chk("R6 index", 32'(cpu_index[7:0]), 32'h14);
    tick();
    chk("R6 req one cycle", 32'(cpu_req[0]), 32'd0);
    wr(4'h1, 32'h0);
    chk("R4 unmasked 13", 32'(cpu_level[3:0]), 32'd13);
    tick();
    chk("R6 withheld index", 32'(cpu_index[7:0]), 32'h14);
    chk("R6 withheld req", 32'(cpu_req[0]), 32'd0);
    cpu_halted[0] = 1'b1; #1;
    chk("R8 wake while withheld", 32'(cpu_wake[0]), 32'd1);
    cpu_halted[0] = 1'b0; #1;
    chk("R8 no wake running", 32'(cpu_wake[0]), 32'd0);
    cpu_ack[0] = 1'b1;
    tick();
    cpu_ack[0] = 1'b0;
    chk("R7 ack clears", 32'(cpu_index[7:0]), 32'd0);
    tick();
    chk("R7 redeliver req", 32'(cpu_req[0]), 32'd1);
    chk("R7 redeliver index", 32'(cpu_index[7:0]), 32'h1D);

    // R5 R10 routing
    wr(4'h2, 32'd2);
    chk("R5 cpu2 gets shared", 32'(cpu_level[11:8]), 32'd13);
    chk("R5 cpu0 loses shared", 32'(cpu_level[3:0]), 32'd0);
    wr(4'h2, 32'd3);
    rd(4'h2, d); chk("R10 target write ignored", d, 32'd2);
    wr(4'hC, 32'h8000_0000);
    chk("R5 max soft vs shared", 32'(cpu_level[11:8]), 32'd15);
    wr(4'hD, 32'h8000_0000);
    chk("R2 cpu2 cleared", 32'(cpu_level[11:8]), 32'd13);

    // R10 absent processor 3
    wr(4'hE, 32'hFFFF_FFFF);
    rd(4'hE, d); chk("R10 read absent", d, 32'd0);
    ev(3'd3, 5'd7, 1'b1);
    chk("R10 levels unchanged", 32'(cpu_level), {20'd0, 4'd13, 4'd0, 4'd0});

    // R9 private event on cpu1
    ev(3'd1, 5'd7, 1'b1);
    rd(4'hA, d); chk("R9 private bit23", d, 32'h0080_0000);
    chk("R9 private level", 32'(cpu_level[7:4]), 32'd7);
    ev(3'd1, 5'd16, 1'b1);
    rd(4'hA, d); chk("R9 private map0 ignored", d, 32'h0080_0000);
    ev(3'd1, 5'd7, 1'b0);
    chk("R9 private clear", 32'(cpu_level[7:4]), 32'd0);

    // R2 partial clear
    wr(4'hA, 32'hC000_0000);
    wr(4'hB, 32'h4000_0000);
    rd(4'hA, d); chk("R2 partial clear", d, 32'h8000_0000);
    chk("R3 after partial clear", 32'(cpu_level[7:4]), 32'd15);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule